// File: doc/BRIEF.md
# Doorbell Interrupt Register Block

A small memory-mapped register block whose only purpose is to drive a single level-sensitive interrupt line that software raises and lowers through register writes. It holds two outbound descriptor words, a control word, an interrupt status word and a software-interrupt word. The software-interrupt word is reached through two aliases: one that ORs bits in and one that clears bits. Certain data bits in writes to some of these registers raise or drop the interrupt as a side effect. The interrupt output is a sticky flip-flop, not a function of the stored bits.

The block sits behind a simple synchronous slave port with byte addresses, separate read and write strobes, and registered read data. Accesses are whole 32-bit little-endian words. An access to an offset that maps to no register, including an offset that is not word aligned, changes nothing, reads as zero and raises a one-cycle diagnostic pulse.

Top module: `irq_doorbell_regs`

## Requirements
- R1: While reset is asserted and after it is released, every stored word is zero, `irqOut` is 0, `rdData` is 0 and `badAccess` is 0.
- R2: A write at offset 0x28 stores the first descriptor word, which reads back unchanged. It has no effect on `irqOut`.
- R3: A write at offset 0x2C stores the second descriptor word. If bit 29 of the write data is 1, `irqOut` is 1 after that clock edge.
- R4: A write at offset 0x4C stores the control word. If data bit 16 is 1, `irqOut` is 0 after the edge. A read at 0x4C returns the stored word with bit 17 forced to 1.
- R5: A write at offset 0x50 stores the status word. If data bit 16 or data bit 29 is 1, `irqOut` is 0 after the edge.
- R6: A write at offset 0x1F0 ORs the data into the software-interrupt word and always sets `irqOut` to 1 after the edge.
- R7: A write at offset 0x1F4 clears every software-interrupt bit that is 1 in the data and always clears `irqOut` to 0 after the edge. A read at either 0x1F0 or 0x1F4 returns the software-interrupt word.
- R8: `rdData` carries the value addressed by a read in the cycle after `rdEn` is sampled high, and is 0 after a cycle without `rdEn`. A read and a write in the same cycle return the value stored before the write.
- R9: `irqOut` keeps its value across any cycle without a write, and across writes that have no interrupt side effect.
- R10: An access at any other offset, including any offset with the low two bits not both zero, leaves all state unchanged and reads as 0. `badAccess` is 1 for exactly the cycle after that access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Byte offset of the access |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Registered read data, valid the cycle after rdEn |
| irqOut | output | 1 | Level interrupt output |
| badAccess | output | 1 | One-cycle pulse after an access to an unmapped offset |

## Verification
The bench builds the block with its default 12-bit offset width and the default offsets. At that width random addresses cover the whole 4 KiB window, so they reach offsets above the highest register, gaps between registers and misaligned offsets next to mapped ones, as well as every register. The random write data sets the raise and drop bits (16 and 29) about half the time, so sequences of raises, drops and neutral writes arise in many orders. Directed cases cover a read and a write to the same register in one cycle, and accesses just off word alignment.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  localparam int REG_W       = 32;
  localparam int RAISE_BIT   = 29;
  localparam int CTRL_DROP   = 16;
  localparam int READY_BIT   = 17;
  localparam int STAT_DROP_A = 16;
  localparam int STAT_DROP_B = 29;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DESC_A,
    SEL_DESC_B,
    SEL_CTRL,
    SEL_STAT,
    SEL_SW
  } regSel_e;

  typedef struct packed {
    logic    wrDescA;
    logic    wrDescB;
    logic    wrCtrl;
    logic    wrStat;
    logic    wrSwSet;
    logic    wrSwClr;
    logic    irqRaise;
    logic    irqDrop;
    logic    rdValid;
    regSel_e rdSel;
    logic    badAcc;
  } ctlStrobe_t;
endpackage

// File: rtl/doorbell_ctrl.sv
module doorbell_ctrl
  import doorbell_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int unsigned OFF_DA   = 32'h028,
  parameter int unsigned OFF_DB   = 32'h02C,
  parameter int unsigned OFF_CTRL = 32'h04C,
  parameter int unsigned OFF_STAT = 32'h050,
  parameter int unsigned OFF_SET  = 32'h1F0,
  parameter int unsigned OFF_CLR  = 32'h1F4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  input  logic              rdEn,
  output ctlStrobe_t        strobe
);
  regSel_e sel;
  logic    isSet;
  logic    isClr;

  always_comb begin
    sel   = SEL_NONE;
    isSet = 1'b0;
    isClr = 1'b0;
    if (addr == ADDR_W'(OFF_DA))        sel = SEL_DESC_A;
    else if (addr == ADDR_W'(OFF_DB))   sel = SEL_DESC_B;
    else if (addr == ADDR_W'(OFF_CTRL)) sel = SEL_CTRL;
    else if (addr == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
    else if (addr == ADDR_W'(OFF_SET)) begin
      sel   = SEL_SW;
      isSet = 1'b1;
    end else if (addr == ADDR_W'(OFF_CLR)) begin
      sel   = SEL_SW;
      isClr = 1'b1;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.wrDescA  = wrEn && (sel == SEL_DESC_A);
    strobe.wrDescB  = wrEn && (sel == SEL_DESC_B);
    strobe.wrCtrl   = wrEn && (sel == SEL_CTRL);
    strobe.wrStat   = wrEn && (sel == SEL_STAT);
    strobe.wrSwSet  = wrEn && isSet;
    strobe.wrSwClr  = wrEn && isClr;
    strobe.irqRaise = (strobe.wrDescB && wrData[RAISE_BIT]) || strobe.wrSwSet;
    strobe.irqDrop  = (strobe.wrCtrl && wrData[CTRL_DROP])
                   || (strobe.wrStat && (wrData[STAT_DROP_A] || wrData[STAT_DROP_B]))
                   || strobe.wrSwClr;
    strobe.rdValid  = rdEn;
    strobe.rdSel    = rdEn ? sel : SEL_NONE;
    strobe.badAcc   = (wrEn || rdEn) && (sel == SEL_NONE);
  end
endmodule

// File: rtl/doorbell_dp.sv
module doorbell_dp
  import doorbell_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             irqOut,
  output logic             badAccess
);
  logic [REG_W-1:0] descA;
  logic [REG_W-1:0] descB;
  logic [REG_W-1:0] ctrlWord;
  logic [REG_W-1:0] statWord;
  logic [REG_W-1:0] swWord;
  logic [REG_W-1:0] rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descA    <= '0;
      descB    <= '0;
      ctrlWord <= '0;
      statWord <= '0;
      swWord   <= '0;
    end else begin
      if (strobe.wrDescA) descA    <= wrData;
      if (strobe.wrDescB) descB    <= wrData;
      if (strobe.wrCtrl)  ctrlWord <= wrData;
      if (strobe.wrStat)  statWord <= wrData;
      if (strobe.wrSwSet) swWord   <= swWord | wrData;
      else if (strobe.wrSwClr) swWord <= swWord & ~wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                irqOut <= 1'b0;
    else if (strobe.irqRaise) irqOut <= 1'b1;
    else if (strobe.irqDrop)  irqOut <= 1'b0;
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_DESC_A: rdNext = descA;
      SEL_DESC_B: rdNext = descB;
      SEL_CTRL: begin
        rdNext            = ctrlWord;
        rdNext[READY_BIT] = 1'b1;
      end
      SEL_STAT:   rdNext = statWord;
      SEL_SW:     rdNext = swWord;
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData    <= '0;
      badAccess <= 1'b0;
    end else begin
      rdData    <= strobe.rdValid ? rdNext : '0;
      badAccess <= strobe.badAcc;
    end
  end
endmodule

// File: rtl/irq_doorbell_regs.sv
module irq_doorbell_regs
  import doorbell_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int unsigned OFF_DA   = 32'h028,
  parameter int unsigned OFF_DB   = 32'h02C,
  parameter int unsigned OFF_CTRL = 32'h04C,
  parameter int unsigned OFF_STAT = 32'h050,
  parameter int unsigned OFF_SET  = 32'h1F0,
  parameter int unsigned OFF_CLR  = 32'h1F4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  input  logic              rdEn,
  output logic [31:0]       rdData,
  output logic              irqOut,
  output logic              badAccess
);
  ctlStrobe_t strobe;

  doorbell_ctrl #(
    .ADDR_W(ADDR_W), .OFF_DA(OFF_DA), .OFF_DB(OFF_DB), .OFF_CTRL(OFF_CTRL),
    .OFF_STAT(OFF_STAT), .OFF_SET(OFF_SET), .OFF_CLR(OFF_CLR)
  ) u_ctrl (
    .addr(addr), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .strobe(strobe)
  );

  doorbell_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdData(rdData), .irqOut(irqOut), .badAccess(badAccess)
  );
endmodule

// File: rtl/doorbell_chk.sv
module doorbell_chk #(
  parameter int          ADDR_W   = 12,
  parameter int unsigned OFF_DA   = 32'h028,
  parameter int unsigned OFF_DB   = 32'h02C,
  parameter int unsigned OFF_CTRL = 32'h04C,
  parameter int unsigned OFF_STAT = 32'h050,
  parameter int unsigned OFF_SET  = 32'h1F0,
  parameter int unsigned OFF_CLR  = 32'h1F4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [31:0]       wrData,
  input logic              rdEn,
  input logic [31:0]       rdData,
  input logic              irqOut,
  input logic              badAccess
);
  logic mapped;
  assign mapped = (addr == ADDR_W'(OFF_DA)) || (addr == ADDR_W'(OFF_DB))
               || (addr == ADDR_W'(OFF_CTRL)) || (addr == ADDR_W'(OFF_STAT))
               || (addr == ADDR_W'(OFF_SET)) || (addr == ADDR_W'(OFF_CLR));

  // R3
  desc_b_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && addr == ADDR_W'(OFF_DB) && wrData[29] |=> irqOut);

  // R4
  ctrl_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && addr == ADDR_W'(OFF_CTRL) && wrData[16] |=> !irqOut);

  // R4
  ctrl_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && addr == ADDR_W'(OFF_CTRL) |=> rdData[17]);

  // R5
  stat_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && addr == ADDR_W'(OFF_STAT) && (wrData[16] || wrData[29]) |=> !irqOut);

  // R6
  sw_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && addr == ADDR_W'(OFF_SET) |=> irqOut);

  // R7
  sw_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && addr == ADDR_W'(OFF_CLR) |=> !irqOut);

  // R8
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> rdData == 32'h0);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(irqOut));

  // R10
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && !mapped |=> rdData == 32'h0 && badAccess);

  // R10
  bad_write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !mapped |=> $stable(irqOut) && badAccess);

  // R10
  good_access_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !((wrEn || rdEn) && !mapped) |=> !badAccess);
endmodule

bind irq_doorbell_regs doorbell_chk #(
  .ADDR_W(ADDR_W), .OFF_DA(OFF_DA), .OFF_DB(OFF_DB), .OFF_CTRL(OFF_CTRL),
  .OFF_STAT(OFF_STAT), .OFF_SET(OFF_SET), .OFF_CLR(OFF_CLR)
) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
  .rdEn(rdEn), .rdData(rdData), .irqOut(irqOut), .badAccess(badAccess)
);

// File: tb/tb_irq_doorbell_regs.sv
module tb_irq_doorbell_regs;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wrEn = 1'b0;
  logic [31:0]   wrData = '0;
  logic          rdEn = 1'b0;
  logic [31:0]   rdData;
  logic          irqOut;
  logic          badAccess;

  int checks = 0;
  int errors = 0;

  logic [31:0] mDescA, mDescB, mCtrl, mStat, mSw;
  logic        mIrq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_doorbell_regs dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .irqOut(irqOut), .badAccess(badAccess)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit isMapped(input logic [AW-1:0] a);
    return a == 12'h028 || a == 12'h02C || a == 12'h04C || a == 12'h050
        || a == 12'h1F0 || a == 12'h1F4;
  endfunction

  function automatic string reqOf(input logic [AW-1:0] a);
    case (a)
      12'h028: return "R2";
      12'h02C: return "R3";
      12'h04C: return "R4";
      12'h050: return "R5";
      12'h1F0: return "R6";
      12'h1F4: return "R7";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] modelRead(input logic [AW-1:0] a);
    case (a)
      12'h028: return mDescA;
      12'h02C: return mDescB;
      12'h04C: return mCtrl | 32'h0002_0000;
      12'h050: return mStat;
      12'h1F0, 12'h1F4: return mSw;
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelWrite(input logic [AW-1:0] a, input logic [31:0] d);
    case (a)
      12'h028: mDescA = d;
      12'h02C: begin mDescB = d; if (d[29]) mIrq = 1'b1; end
      12'h04C: begin mCtrl = d; if (d[16]) mIrq = 1'b0; end
      12'h050: begin mStat = d; if (d[16] || d[29]) mIrq = 1'b0; end
      12'h1F0: begin mSw = mSw | d; mIrq = 1'b1; end
      12'h1F4: begin mSw = mSw & ~d; mIrq = 1'b0; end
      default: ;
    endcase
  endtask

  // Drive one access just after a falling edge, check results at the next falling edge.
  task automatic access(input logic [AW-1:0] a, input logic we, input logic [31:0] d,
                        input logic re);
    logic [31:0] expRd;
    logic        expBad;
    string       tag;
    expRd  = re ? modelRead(a) : 32'h0;
    expBad = (we || re) && !isMapped(a);
    tag    = reqOf(a);
    if (we) modelWrite(a, d);
    addr = a; wrEn = we; wrData = d; rdEn = re;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check(re ? (we ? "R8" : tag) : "R8", rdData, expRd);
    check(we ? tag : "R9", {31'b0, irqOut}, {31'b0, mIrq});
    check("R10", {31'b0, badAccess}, {31'b0, expBad});
  endtask

  function automatic logic [AW-1:0] pickAddr();
    int r = $urandom_range(0, 9);
    case (r)
      0: return 12'h028;
      1: return 12'h02C;
      2: return 12'h04C;
      3: return 12'h050;
      4: return 12'h1F0;
      5: return 12'h1F4;
      6: return 12'h028 + AW'($urandom_range(1, 3));
      default: return AW'($urandom);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    mDescA = '0; mDescB = '0; mCtrl = '0; mStat = '0; mSw = '0; mIrq = 1'b0;
    // R1: outputs during reset
    repeat (3) @(negedge clk);
    check("R1", rdData, 32'h0);
    check("R1", {31'b0, irqOut}, 32'h0);
    check("R1", {31'b0, badAccess}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: every stored word reads zero after reset (ctrl shows forced bit)
    access(12'h028, 1'b0, 32'h0, 1'b1);
    access(12'h02C, 1'b0, 32'h0, 1'b1);
    access(12'h04C, 1'b0, 32'h0, 1'b1);
    access(12'h050, 1'b0, 32'h0, 1'b1);
    access(12'h1F0, 1'b0, 32'h0, 1'b1);
    check("R1", {31'b0, irqOut}, 32'h0);

    // Directed corner cases
    access(12'h02C, 1'b1, 32'h2000_0000, 1'b0);  // R3 raise
    access(12'h028, 1'b1, 32'hFFFF_FFFF, 1'b0);  // R2 no effect on irq
    access(12'h02C, 1'b1, 32'h1000_0000, 1'b0);  // R9 neutral B write keeps irq
    access(12'h04C, 1'b1, 32'h0000_0000, 1'b1);  // R4 no drop, read old + ready
    access(12'h04C, 1'b1, 32'h0001_0000, 1'b1);  // R4 drop
    access(12'h04C, 1'b0, 32'h0, 1'b1);          // R4 readback with ready bit
    access(12'h1F0, 1'b1, 32'h0000_00F0, 1'b0);  // R6 set
    access(12'h1F0, 1'b1, 32'h0000_0F00, 1'b0);  // R6 OR accumulates
    access(12'h050, 1'b1, 32'h2000_0000, 1'b0);  // R5 drop via bit 29
    access(12'h1F0, 1'b1, 32'h0, 1'b0);          // R6 raise with zero data
    access(12'h050, 1'b1, 32'h0001_0000, 1'b0);  // R5 drop via bit 16
    access(12'h1F4, 1'b1, 32'h0000_0030, 1'b1);  // R7 clear, read old value
    access(12'h1F4, 1'b0, 32'h0, 1'b1);          // R7 read via clear alias
    access(12'h1F0, 1'b0, 32'h0, 1'b1);          // R7 read via set alias
    access(12'h028, 1'b1, 32'h1234_5678, 1'b1);  // R8 read returns pre-write value
    access(12'h028, 1'b0, 32'h0, 1'b1);          // R2 readback
    access(12'h1F0, 1'b1, 32'h1, 1'b0);
    access(12'h029, 1'b1, 32'h0001_0000, 1'b1);  // R10 misaligned, no drop
    access(12'h1F8, 1'b1, 32'hFFFF_FFFF, 1'b1);  // R10 beyond map
    access(12'h02A, 1'b0, 32'h0, 1'b1);          // R10 misaligned read
    access(12'h000, 1'b0, 32'h0, 1'b0);          // R8/R9 idle cycle
    access(12'h028, 1'b0, 32'h0, 1'b1);          // R10 descA unchanged

    // Random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      logic [31:0]   d;
      int            kind;
      a    = pickAddr();
      d    = $urandom;
      kind = $urandom_range(0, 3);
      access(a, kind[0], d, kind[1]);
    end

    // Final sweep of every register
    access(12'h028, 1'b0, 32'h0, 1'b1);
    access(12'h02C, 1'b0, 32'h0, 1'b1);
    access(12'h04C, 1'b0, 32'h0, 1'b1);
    access(12'h050, 1'b0, 32'h0, 1'b1);
    access(12'h1F4, 1'b0, 32'h0, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule